// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block shifts a 32-bit operand by a given amount in one of four ways: logical left, logical right, arithmetic right or rotate right. It returns the shifted value and the carry bit that the shift pushes out. It sits in the second-operand path of a processor datapath.

The shift amount comes from one of two sources, and its meaning depends on the source:

- **Immediate source.** The amount is a 5-bit field. An encoded zero takes a special meaning for each shift kind. For a right shift it stands for 32. For a rotate it stands for a one-bit rotate through the incoming carry.
- **Register source.** The amount is the low byte of a register. Zero means "no change to value or carry", and amounts of 32 and above are well defined.

A small decoder runs alongside the shifter. It splits a 12-bit instruction shift field into the shift kind, the amount source, the immediate amount and the index of the amount register. The decoder output is combinational.

The shift result and carry are captured in one output register stage. They therefore appear one clock after the inputs are presented.

Top module: `opshift_top`

## Requirements
- R1: Shift kind code 00 is logical left. An amount of 0 returns the operand unchanged with carry equal to the incoming carry. Amounts 1..31 set carry to operand bit (32 - amount). An amount of 32 returns 0 with carry equal to operand bit 0. An amount above 32 (register source only) returns 0 with carry 0.
- R2: Kind code 01 is logical right. With the immediate source, an encoded amount of 0 acts as a shift of 32: the result is 0 and the carry is operand bit 31.
- R3: For a logical right shift by 1..31, the carry is operand bit (amount - 1). With the register source, an amount of 32 gives 0 with carry equal to bit 31, and an amount above 32 gives 0 with carry 0.
- R4: Kind code 10 is arithmetic right. An immediate 0, or any amount of 32 or more, fills every result bit with operand bit 31, and the carry equals bit 31. For amounts 1..31, the carry is operand bit (amount - 1).
- R5: Kind code 11 with the immediate source and an encoded amount of 0 is a one-bit rotate through carry. The result is {carry_in, operand[31:1]} and the carry is operand bit 0.
- R6: A rotate by any other nonzero amount rotates right by the amount modulo 32. The carry equals bit 31 of the result, including when the amount is a nonzero multiple of 32.
- R7: With the register source, an amount of 0 returns the operand unchanged with carry equal to carry_in, for every shift kind.
- R8: The decoder reports the following fields of the shift field: bit 4 as register-source, bits 6:5 as the kind, bits 11:7 as the immediate amount, and bits 11:8 as the amount-register index.
- R9: The result and carry appear on the outputs one clock after the inputs. While reset is low, both outputs read 0.
- R10: With the immediate source, only amount bits 4:0 are used; bits 7:5 have no effect on the result or carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Active-low synchronous reset |
| op_val | input | 32 | Operand to shift |
| sh_kind | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| sh_amt | input | 8 | Shift amount; low 5 bits only when immediate |
| amt_by_reg | input | 1 | 1 = amount from register byte, 0 = immediate field |
| carry_in | input | 1 | Current carry flag |
| shift_field | input | 12 | Instruction shift field to decode |
| dec_kind | output | 2 | Decoded shift kind |
| dec_by_reg | output | 1 | Decoded amount source |
| dec_imm_amt | output | 5 | Decoded immediate amount |
| dec_reg_idx | output | 4 | Decoded amount-register index |
| result_q | output | 32 | Registered shift result |
| carry_q | output | 1 | Registered shifter carry-out |

## Verification
The field decoder and the shifter act in the same cycle on unrelated inputs. The bench therefore drives a fresh shift field alongside every shift operation. It checks the decoder outputs combinationally in the same cycle, while the shift result is checked one clock later. This shows that neither path disturbs the other.

The incoming carry serves two of the shifter's functions: it is passed straight through for a zero shift, and it is the bit shifted in for the rotate through carry. Both carry values are applied to every shift kind, amount and source, and each outcome is compared with the bench's behavioural model.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
    localparam int DATA_W  = 32;
    localparam int AMT_W   = 8;
    localparam int IMM_W   = $clog2(DATA_W);
    localparam int FIELD_W = 12;
    localparam int IDX_W   = 4;
    localparam int EFF_W   = AMT_W + 2;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cy;
    } shift_out_t;
endpackage

// File: rtl/opshift_field_dec.sv
module opshift_field_dec
    import opshift_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int IW = IMM_W,
    parameter int XW = IDX_W
) (
    input  logic [FW-1:0] field_i,
    output logic [1:0]    kind_o,
    output logic          by_reg_o,
    output logic [IW-1:0] imm_amt_o,
    output logic [XW-1:0] reg_idx_o
);
    localparam int KIND_LO = 5;
    localparam int IMM_LO  = 7;
    localparam int IDX_LO  = 8;

    always_comb begin
        by_reg_o  = field_i[4];
        kind_o    = field_i[KIND_LO +: 2];
        imm_amt_o = field_i[IMM_LO +: IW];
        reg_idx_o = field_i[IDX_LO +: XW];
    end

    always_comb begin
        if (field_i[4] === 1'b1 || field_i[4] === 1'b0)
            AST_DEC_SRC: assert (by_reg_o == field_i[4] && reg_idx_o == imm_amt_o[IW-1:1]); // R8
    end
endmodule

// File: rtl/opshift_amt_norm.sv
module opshift_amt_norm
    import opshift_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = AMT_W,
    parameter int EW = EFF_W
) (
    input  logic [1:0]    kind_i,
    input  logic [AW-1:0] amt_i,
    input  logic          by_reg_i,
    output logic [EW-1:0] eff_o,
    output logic          hold_o,
    output logic          rrx_o
);
    localparam int IW = $clog2(DW);

    logic [IW-1:0] imm_amt;

    always_comb begin
        imm_amt = amt_i[IW-1:0];
        eff_o   = '0;
        hold_o  = 1'b0;
        rrx_o   = 1'b0;
        if (by_reg_i) begin
            eff_o  = EW'(amt_i);
            hold_o = (amt_i == '0);
        end else if (imm_amt == '0) begin
            unique case (shift_kind_e'(kind_i))
                SK_LSL:  hold_o = 1'b1;
                SK_ROR:  rrx_o  = 1'b1;
                default: eff_o  = EW'(DW);
            endcase
        end else begin
            eff_o = EW'(imm_amt);
        end
    end
endmodule

// File: rtl/opshift_core.sv
module opshift_core
    import opshift_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int EW = EFF_W
) (
    input  logic [DW-1:0] val_i,
    input  logic [1:0]    kind_i,
    input  logic [EW-1:0] eff_i,
    input  logic          hold_i,
    input  logic          rrx_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    localparam int IW = $clog2(DW);

    logic [2*DW-1:0] rot_dbl;
    int              n;

    always_comb begin
        n       = int'(eff_i);
        rot_dbl = {val_i, val_i} >> eff_i[IW-1:0];
        res_o   = val_i;
        cy_o    = cin_i;
        if (hold_i) begin
            res_o = val_i;
            cy_o  = cin_i;
        end else if (rrx_i) begin
            res_o = {cin_i, val_i[DW-1:1]};
            cy_o  = val_i[0];
        end else begin
            unique case (shift_kind_e'(kind_i))
                SK_LSL: begin
                    if (n < DW) begin
                        res_o = val_i << n;
                        cy_o  = val_i[DW-n];
                    end else if (n == DW) begin
                        res_o = '0;
                        cy_o  = val_i[0];
                    end else begin
                        res_o = '0;
                        cy_o  = 1'b0;
                    end
                end
                SK_LSR: begin
                    if (n < DW) begin
                        res_o = val_i >> n;
                        cy_o  = val_i[n-1];
                    end else if (n == DW) begin
                        res_o = '0;
                        cy_o  = val_i[DW-1];
                    end else begin
                        res_o = '0;
                        cy_o  = 1'b0;
                    end
                end
                SK_ASR: begin
                    if (n < DW) begin
                        res_o = DW'($signed(val_i) >>> n);
                        cy_o  = val_i[n-1];
                    end else begin
                        res_o = {DW{val_i[DW-1]}};
                        cy_o  = val_i[DW-1];
                    end
                end
                default: begin
                    res_o = rot_dbl[DW-1:0];
                    cy_o  = rot_dbl[DW-1];
                end
            endcase
        end
    end

    always_comb begin
        if (hold_i)
            AST_HOLD_PASS: assert (res_o == val_i && cy_o == cin_i); // R7
        if (!hold_i && !rrx_i && kind_i == 2'b00 && int'(eff_i) > DW)
            AST_LSL_FLUSH: assert (res_o == '0 && !cy_o); // R1
        if (!hold_i && !rrx_i && kind_i == 2'b10 && int'(eff_i) >= DW)
            AST_ASR_FILL: assert (res_o == {DW{val_i[DW-1]}} && cy_o == val_i[DW-1]); // R4
        if (rrx_i)
            AST_RRX_BITS: assert (res_o[DW-1] == cin_i && cy_o == val_i[0]); // R5
        if (!hold_i && !rrx_i && kind_i == 2'b11)
            AST_ROR_MSB: assert (cy_o == res_o[DW-1]); // R6
    end
endmodule

// File: rtl/opshift_top.sv
module opshift_top
    import opshift_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = AMT_W,
    parameter int FW = FIELD_W,
    parameter int XW = IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         op_val,
    input  logic [1:0]            sh_kind,
    input  logic [AW-1:0]         sh_amt,
    input  logic                  amt_by_reg,
    input  logic                  carry_in,
    input  logic [FW-1:0]         shift_field,
    output logic [1:0]            dec_kind,
    output logic                  dec_by_reg,
    output logic [$clog2(DW)-1:0] dec_imm_amt,
    output logic [XW-1:0]         dec_reg_idx,
    output logic [DW-1:0]         result_q,
    output logic                  carry_q
);
    localparam int IW = $clog2(DW);
    localparam int EW = AW + 2;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          cy;
    } stage_t;

    logic [EW-1:0] eff_amt;
    logic          hold_val;
    logic          rrx_sel;
    logic [DW-1:0] core_res;
    logic          core_cy;
    stage_t        st_d, st_q;

    opshift_field_dec #(.FW(FW), .IW(IW), .XW(XW)) u_dec (
        .field_i   (shift_field),
        .kind_o    (dec_kind),
        .by_reg_o  (dec_by_reg),
        .imm_amt_o (dec_imm_amt),
        .reg_idx_o (dec_reg_idx)
    );

    opshift_amt_norm #(.DW(DW), .AW(AW), .EW(EW)) u_norm (
        .kind_i   (sh_kind),
        .amt_i    (sh_amt),
        .by_reg_i (amt_by_reg),
        .eff_o    (eff_amt),
        .hold_o   (hold_val),
        .rrx_o    (rrx_sel)
    );

    opshift_core #(.DW(DW), .EW(EW)) u_core (
        .val_i  (op_val),
        .kind_i (sh_kind),
        .eff_i  (eff_amt),
        .hold_i (hold_val),
        .rrx_i  (rrx_sel),
        .cin_i  (carry_in),
        .res_o  (core_res),
        .cy_o   (core_cy)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = core_res;
        st_d.cy  = core_cy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_q = st_q.res;
    assign carry_q  = st_q.cy;

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (result_q == '0 && !carry_q)); // R9
endmodule

// File: tb/opshift_top_test.sv
module opshift_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_val = '0;
    logic [1:0]  sh_kind = '0;
    logic [7:0]  sh_amt = '0;
    logic        amt_by_reg = 1'b0;
    logic        carry_in = 1'b0;
    logic [11:0] shift_field = '0;
    logic [1:0]  dec_kind;
    logic        dec_by_reg;
    logic [4:0]  dec_imm_amt;
    logic [3:0]  dec_reg_idx;
    logic [31:0] result_q;
    logic        carry_q;

    int checks = 0;
    int errors = 0;
    logic [32:0] q_exp[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    opshift_top uut (
        .clk(clk), .rst_n(rst_n), .op_val(op_val), .sh_kind(sh_kind),
        .sh_amt(sh_amt), .amt_by_reg(amt_by_reg), .carry_in(carry_in),
        .shift_field(shift_field), .dec_kind(dec_kind), .dec_by_reg(dec_by_reg),
        .dec_imm_amt(dec_imm_amt), .dec_reg_idx(dec_reg_idx),
        .result_q(result_q), .carry_q(carry_q)
    );

    function automatic logic [32:0] ref_model(input int kind, input logic [31:0] v,
                                              input int amt, input bit byreg, input bit cin);
        int a;
        longint unsigned x;
        logic [31:0] r;
        x = 64'(v);
        if (byreg) begin
            if (amt == 0) return {cin, v};
            a = amt;
        end else begin
            a = amt % 32;
            if (a == 0) begin
                if (kind == 0) return {cin, v};
                if (kind == 3) return {v[0], cin, v[31:1]};
                a = 32;
            end
        end
        case (kind)
            0: begin
                if (a > 32) return 33'd0;
                x = x << a;
                return x[32:0];
            end
            1: begin
                if (a > 32) return 33'd0;
                x = (x << 1) >> a;
                return {x[0], x[32:1]};
            end
            2: begin
                if (a >= 32) return {v[31], {32{v[31]}}};
                r = 32'($signed(v) >>> a);
                return {v[a-1], r};
            end
            default: begin
                a = a % 32;
                r = (v >> a) | (v << (32 - a));
                return {r[31], r};
            end
        endcase
    endfunction

    function automatic string tag_of(input int kind, input int amt, input bit byreg);
        if (byreg && amt == 0) return "R7";
        if (!byreg && amt > 31) return "R10";
        case (kind)
            0: return "R1";
            1: return byreg ? "R3" : ((amt % 32 == 0) ? "R2" : "R3");
            2: return "R4";
            default: return (!byreg && amt % 32 == 0) ? "R5" : "R6";
        endcase
    endfunction

    task automatic compare_head();
        logic [32:0] e;
        string t;
        if (q_exp.size() == 0) return;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if ({carry_q, result_q} !== e) begin
            errors++;
            $display("FAIL %s: got carry=%0b res=%08h, expected carry=%0b res=%08h",
                     t, carry_q, result_q, e[32], e[31:0]);
        end
    endtask

    task automatic check_decode(input logic [11:0] f);
        checks++;
        if (dec_by_reg !== f[4] || dec_kind !== f[6:5] ||
            dec_imm_amt !== f[11:7] || dec_reg_idx !== f[11:8]) begin
            errors++;
            $display("FAIL R8: field=%03h got src=%0b kind=%0d imm=%0d idx=%0d, expected src=%0b kind=%0d imm=%0d idx=%0d",
                     f, dec_by_reg, dec_kind, dec_imm_amt, dec_reg_idx,
                     f[4], f[6:5], f[11:7], f[11:8]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int amts[6] = '{0, 1, 31, 32, 33, 255};
        logic [31:0] vals[3] = '{32'h8000_0001, 32'h7ABC_DEF0, 32'hFFFF_FFFE};
        int fcount = 0;

        op_val = 32'hDEAD_BEEF;
        sh_amt = 8'd3;
        carry_in = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (result_q !== '0 || carry_q !== 1'b0) begin
            errors++;
            $display("FAIL R9: got res=%08h carry=%0b in reset, expected 0", result_q, carry_q);
        end
        rst_n = 1'b1;

        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 2; m++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int ai = 0; ai < 6; ai++) begin
                        for (int vi = 0; vi < 3; vi++) begin
                            @(negedge clk);
                            compare_head();
                            sh_kind     = 2'(k);
                            amt_by_reg  = m[0];
                            carry_in    = c[0];
                            sh_amt      = 8'(amts[ai]);
                            op_val      = vals[vi];
                            shift_field = 12'(fcount * 613 + 37);
                            fcount++;
                            q_exp.push_back(ref_model(k, vals[vi], amts[ai], m[0], c[0]));
                            q_tag.push_back(tag_of(k, amts[ai], m[0]));
                            #1;
                            check_decode(shift_field);
                        end
                    end
                end
            end
        end
        @(negedge clk);
        compare_head();

        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (result_q !== '0 || carry_q !== 1'b0) begin
            errors++;
            $display("FAIL R9: got res=%08h carry=%0b after reset, expected 0", result_q, carry_q);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule